// File: doc/BRIEF.md
# Dual-Mode Serial Baud Rate Generator

This block derives the timing pulses for one asynchronous serial channel from the system clock. Its first output is a serial clock enable, a one-cycle pulse at the rate of the selected clock source. There are three sources. The fixed-prescaler path divides the system clock by 10 or 30 and then by a power of two. The programmable counter path divides by twice the sum of a 16-bit time constant and two. The bypass path follows the rising edges of an external clock input.

The second output is the bit-rate enable. It is either the serial clock enable itself, for a 1x bit clock, or every 16th or 64th pulse of it, for an oversampled receiver. The same ratio flag chooses between 10 and 30 in the prescaler and between 16 and 64 in the final stage.

The configuration fields are held in internal registers that reset to zero. Any change to them restarts all dividers from a known phase. The time constant can be changed at any time, and the counter takes it in only when it wraps.

Top module: `baud_gen`

## Requirements
- R1: With `srcSel` not equal to 3'b111 and `counterMode` = 0, the system clock is first divided by 10 when `divRatio` = 0, or by 30 when `divRatio` = 1.
- R2: In that prescaler mode, the prescaled clock is further divided by 2^`srcSel`, so `srcSel` 0 to 6 gives divide-by 1, 2, 4, 8, 16, 32 and 64. The `serClkEn` period is 10·2^srcSel or 30·2^srcSel system cycles.
- R3: With `srcSel` not equal to 3'b111 and `counterMode` = 1, `serClkEn` pulses once every 2·(`timeConst`+2) system cycles, and `srcSel` has no other effect.
- R4: In counter mode, a new `timeConst` value is taken in only when the counter reaches terminal count. The period in progress when the value changes keeps the old length, and the next period uses the new value.
- R5: With `srcSel` = 3'b111, `extClk` passes through a two-flop synchroniser. `serClkEn` gives exactly one pulse for each rising edge of `extClk` and none for a falling edge, so its period equals the `extClk` period.
- R6: With `bitX1` = 1, `bitRateEn` is identical to `serClkEn`.
- R7: With `bitX1` = 0, `bitRateEn` pulses on every 16th `serClkEn` pulse when `divRatio` = 0, and on every 64th when `divRatio` = 1.
- R8: Both outputs are single-cycle pulses in the system clock domain, and `bitRateEn` is never high without `serClkEn`.
- R9: Reset (`rstN` low) clears the configuration registers to zero and holds both outputs low. After release with all inputs at zero, the first `serClkEn` pulse is seen on the 9th falling clock edge after the first rising edge.
- R10: A change of any configuration field is registered on the next rising edge, and that same edge clears all dividers. In prescaler mode, the first `serClkEn` after a change written at a falling edge appears exactly 10·2^srcSel or 30·2^srcSel falling edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 3 | Power-of-two select (0 to 6) or external source (7) |
| counterMode | input | 1 | 0: fixed prescaler path, 1: programmable counter path |
| divRatio | input | 1 | Selects 10/30 in the prescaler and 16/64 in the final stage |
| bitX1 | input | 1 | 1: serial clock is used directly as the bit clock |
| timeConst | input | 16 | Time constant for counter mode |
| extClk | input | 1 | External clock, asynchronous to clk |
| serClkEn | output | 1 | One-cycle pulse at the selected serial clock rate |
| bitRateEn | output | 1 | One-cycle pulse at the bit rate |

## Verification
The hardest situation to reach from the ports is a time-constant change in the middle of a counter period. The new value has to arrive after the reload edge and before the next terminal count. To get there, the stimulus waits for a `serClkEn` pulse, steps one falling edge, and then writes the new constant. It then measures the remaining period and the one after it.

The restart phase after a configuration change is checked by counting falling edges from the write to the first pulse. Every source, ratio and final-stage setting is covered by a table of configurations, and each entry is checked by measuring pulse-to-pulse gaps on both outputs.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int SEL_W     = 3;
  localparam int PRE_LO    = 10;
  localparam int PRE_HI    = 30;
  localparam int FIN_LO    = 16;
  localparam int FIN_HI    = 64;
  localparam int PRE_W     = $clog2(PRE_HI);
  localparam int POW_W     = (1 << SEL_W) - 2;
  localparam int FIN_W     = $clog2(FIN_HI);

  typedef struct packed {
    logic [SEL_W-1:0] srcSel;
    logic             counterMode;
    logic             divRatio;
    logic             bitX1;
  } cfg_t;

  typedef struct packed {
    logic             clr;
    logic             runPre;
    logic             runCounter;
    logic             useExt;
    logic             bypassFinal;
    logic [PRE_W-1:0] preLast;
    logic [POW_W-1:0] pow2Mask;
    logic [FIN_W-1:0] finalMask;
  } strobes_t;
endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             counterMode,
  input  logic             divRatio,
  input  logic             bitX1,
  output strobes_t         strobes
);
  localparam logic [SEL_W-1:0] EXT_CODE = '1;

  cfg_t cfgIn;
  cfg_t cfgQ;
  logic cfgChanged;

  assign cfgIn      = '{srcSel: srcSel, counterMode: counterMode,
                        divRatio: divRatio, bitX1: bitX1};
  assign cfgChanged = (cfgIn != cfgQ);

  // configuration register, cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgIn;
  end

  logic isExt;
  assign isExt = (cfgQ.srcSel == EXT_CODE);

  always_comb begin
    strobes             = '0;
    strobes.clr         = cfgChanged;
    strobes.useExt      = isExt;
    strobes.runPre      = !isExt && !cfgQ.counterMode;
    strobes.runCounter  = !isExt && cfgQ.counterMode;
    strobes.bypassFinal = cfgQ.bitX1;
    strobes.preLast     = cfgQ.divRatio ? PRE_W'(PRE_HI - 1) : PRE_W'(PRE_LO - 1);
    strobes.finalMask   = cfgQ.divRatio ? FIN_W'(FIN_HI - 1) : FIN_W'(FIN_LO - 1);
    strobes.pow2Mask    = POW_W'((32'd1 << cfgQ.srcSel) - 32'd1);
  end

  // R10: a detected change is registered on the following edge
  assert_cfg_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgChanged |=> (cfgQ == $past(cfgIn)));
endmodule

// File: rtl/baud_gen_dp.sv
module baud_gen_dp
  import baud_gen_pkg::*;
#(
  parameter int TC_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strobes,
  input  logic [TC_W-1:0] timeConst,
  input  logic            extClk,
  output logic            serClkEn,
  output logic            bitRateEn
);
  localparam int CNT_W = TC_W + 2;

  logic [PRE_W-1:0]     preCnt;
  logic [POW_W-1:0]     pow2Cnt;
  logic [CNT_W-1:0]     downCnt;
  logic [FIN_W-1:0]     finCnt;
  logic [SYNC_STAGES:0] syncQ;
  logic [CNT_W-1:0]     loadVal;

  logic preTick, pow2Match, cntTick, extTick, finMatch;

  // 2*(TC+2) period: load 2*TC+3 and count down through zero
  assign loadVal   = CNT_W'({timeConst, 1'b1}) + CNT_W'(2);
  assign preTick   = strobes.runPre && (preCnt == strobes.preLast);
  assign pow2Match = ((pow2Cnt & strobes.pow2Mask) == strobes.pow2Mask);
  assign cntTick   = strobes.runCounter && (downCnt == '0);
  assign extTick   = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];
  assign finMatch  = ((finCnt & strobes.finalMask) == strobes.finalMask);

  // fixed prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             preCnt <= '0;
    else if (strobes.clr || !strobes.runPre) preCnt <= '0;
    else if (preCnt == strobes.preLast)    preCnt <= '0;
    else                                   preCnt <= preCnt + 1'b1;
  end

  // power-of-two divider after the prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pow2Cnt <= '0;
    else if (strobes.clr) pow2Cnt <= '0;
    else if (preTick) begin
      if (pow2Match) pow2Cnt <= '0;
      else           pow2Cnt <= pow2Cnt + 1'b1;
    end
  end

  // programmable time-constant counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            downCnt <= '0;
    else if (strobes.clr) downCnt <= loadVal;
    else if (strobes.runCounter) begin
      if (downCnt == '0) downCnt <= loadVal;
      else               downCnt <= downCnt - 1'b1;
    end
  end

  // external clock synchroniser plus edge-history flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], extClk};
  end

  always_comb begin
    if (strobes.useExt)          serClkEn = extTick;
    else if (strobes.runCounter) serClkEn = cntTick;
    else                         serClkEn = preTick && pow2Match;
  end

  // final 1x / 16x / 64x stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            finCnt <= '0;
    else if (strobes.clr) finCnt <= '0;
    else if (serClkEn && !strobes.bypassFinal) begin
      if (finMatch) finCnt <= '0;
      else          finCnt <= finCnt + 1'b1;
    end
  end

  assign bitRateEn = strobes.bypassFinal ? serClkEn : (serClkEn && finMatch);

  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runPre |-> (preCnt <= strobes.preLast));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.runCounter && !strobes.clr && downCnt == '0) |=>
      (downCnt == CNT_W'({$past(timeConst), 1'b1}) + CNT_W'(2)));

  assert_final_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bitRateEn && !strobes.bypassFinal && !strobes.clr) |=> (finCnt == '0));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    serClkEn |=> !serClkEn);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> (preCnt == '0 && pow2Cnt == '0 && finCnt == '0));
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int TC_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             counterMode,
  input  logic             divRatio,
  input  logic             bitX1,
  input  logic [TC_W-1:0]  timeConst,
  input  logic             extClk,
  output logic             serClkEn,
  output logic             bitRateEn
);
  strobes_t strobes;

  baud_gen_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .srcSel      (srcSel),
    .counterMode (counterMode),
    .divRatio    (divRatio),
    .bitX1       (bitX1),
    .strobes     (strobes)
  );

  baud_gen_dp #(.TC_W(TC_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .timeConst (timeConst),
    .extClk    (extClk),
    .serClkEn  (serClkEn),
    .bitRateEn (bitRateEn)
  );
endmodule

// File: tb/baud_gen_tb_top.sv
`timescale 1ns/1ps
module baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  srcSel = '0;
  logic        counterMode = 1'b0;
  logic        divRatio = 1'b0;
  logic        bitX1 = 1'b0;
  logic [15:0] timeConst = '0;
  logic        extClk = 1'b0;
  logic        serClkEn, bitRateEn;

  int checks = 0;
  int fails = 0;
  int extHalf = 0;
  int extCnt = 0;
  int r8Bad = 0;
  bit serPrev = 1'b0;
  bit done = 1'b0;

  localparam int LIM = 30000;
  localparam int NV  = 12;
  // {srcSel, counterMode, divRatio, bitX1, timeConst, extHalf, serPeriod, bitPeriod}
  localparam logic [63:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 1'b0, 16'd0,   8'd0, 17'd10,  17'd160},   // R1 R7
    {3'd0, 1'b0, 1'b1, 1'b1, 16'd0,   8'd0, 17'd30,  17'd30},    // R1 R6
    {3'd3, 1'b0, 1'b0, 1'b1, 16'd0,   8'd0, 17'd80,  17'd80},    // R2
    {3'd6, 1'b0, 1'b0, 1'b1, 16'd0,   8'd0, 17'd640, 17'd640},   // R2
    {3'd2, 1'b0, 1'b1, 1'b0, 16'd0,   8'd0, 17'd120, 17'd7680},  // R2 R7
    {3'd5, 1'b0, 1'b0, 1'b1, 16'd0,   8'd0, 17'd320, 17'd320},   // R2
    {3'd0, 1'b1, 1'b0, 1'b1, 16'd0,   8'd0, 17'd4,   17'd4},     // R3
    {3'd4, 1'b1, 1'b0, 1'b0, 16'd5,   8'd0, 17'd14,  17'd224},   // R3 R7
    {3'd0, 1'b1, 1'b1, 1'b0, 16'd100, 8'd0, 17'd204, 17'd13056}, // R3 R7
    {3'd7, 1'b0, 1'b0, 1'b1, 16'd0,   8'd4, 17'd8,   17'd8},     // R5
    {3'd7, 1'b1, 1'b0, 1'b0, 16'd9,   8'd5, 17'd10,  17'd160},   // R5
    {3'd1, 1'b0, 1'b0, 1'b1, 16'd0,   8'd0, 17'd20,  17'd20}     // R2
  };

  baud_gen dut_i (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .counterMode(counterMode),
    .divRatio(divRatio), .bitX1(bitX1), .timeConst(timeConst),
    .extClk(extClk), .serClkEn(serClkEn), .bitRateEn(bitRateEn)
  );

  always #4 clk = ~clk;

  // external clock source, toggled every extHalf system cycles
  initial forever begin
    @(negedge clk);
    if (extHalf != 0) begin
      extCnt++;
      if (extCnt >= extHalf) begin
        extClk = ~extClk;
        extCnt = 0;
      end
    end
  end

  // R8 monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (serPrev && serClkEn) r8Bad++;
      if (bitRateEn && !serClkEn) r8Bad++;
    end
    serPrev = serClkEn;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // falling edges until the chosen output is next high (0 if high now)
  task automatic waitHigh(input bit useBit, output int n);
    n = 0;
    while (!(useBit ? bitRateEn : serClkEn) && n < LIM) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic gapOf(input bit useBit, output int gap);
    int dummy;
    waitHigh(useBit, dummy);
    @(negedge clk);
    waitHigh(useBit, gap);
    gap = gap + 1;
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n, g;
    // R9: outputs held low during reset
    repeat (3) @(negedge clk);
    check("R9 serClkEn in reset", serClkEn, 0);
    check("R9 bitRateEn in reset", bitRateEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    n = 1;
    while (!serClkEn && n < LIM) begin
      @(negedge clk);
      n++;
    end
    check("R9 first pulse after reset", n, 9);

    // table of configurations
    for (int i = 0; i < NV; i++) begin
      {srcSel, counterMode, divRatio, bitX1} = VEC[i][63:58];
      timeConst = VEC[i][57:42];
      extHalf   = int'(VEC[i][41:34]);
      repeat (2) @(negedge clk);
      gapOf(1'b0, g);
      check($sformatf("R1/R2/R3/R5 serClkEn period vec %0d", i), g, int'(VEC[i][33:17]));
      gapOf(1'b1, g);
      check($sformatf("R6/R7 bitRateEn period vec %0d", i), g, int'(VEC[i][16:0]));
    end
    extHalf = 0;

    // R10: restart phase after a configuration write
    {srcSel, counterMode, divRatio, bitX1} = 6'b000_0_0_1;
    repeat (40) @(negedge clk);
    divRatio = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!serClkEn && n < LIM);
    check("R10 first pulse after change to /30", n, 30);
    srcSel = 3'd2;
    divRatio = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!serClkEn && n < LIM);
    check("R10 first pulse after change to /40", n, 40);

    // R4: time constant change in the middle of a period
    counterMode = 1'b1;
    srcSel = 3'd0;
    timeConst = 16'd10;
    repeat (60) @(negedge clk);
    waitHigh(1'b0, n);
    @(negedge clk);
    timeConst = 16'd2;
    waitHigh(1'b0, n);
    check("R4 period in progress keeps old constant", n + 1, 24);
    gapOf(1'b0, g);
    check("R4 next period uses new constant", g, 8);
    check("R6 x1 bit pulse tracks serial pulse", bitRateEn, serClkEn);

    // R3: srcSel has no effect in counter mode
    srcSel = 3'd5;
    repeat (2) @(negedge clk);
    gapOf(1'b0, g);
    check("R3 srcSel ignored in counter mode", g, 8);

    // R5: falling edges alone give no pulse
    srcSel = 3'd7;
    counterMode = 1'b0;
    extClk = 1'b1;
    repeat (6) @(negedge clk);
    extClk = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (serClkEn) n++;
    end
    check("R5 no pulse on falling edge", n, 0);
    extClk = 1'b1;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (serClkEn) n++;
    end
    check("R5 one pulse per rising edge", n, 1);

    check("R8 single-cycle pulses and bit within serial", r8Bad, 0);
    finishRun();
  end
endmodule